// File: doc/BRIEF.md
# Fused Multiply-Add Special-Operand Screen

This block sits in front of the arithmetic datapath of a single-precision fused multiply-add that computes z + (x × y). It looks at the three raw 32-bit encodings before any mantissa work starts. It sorts each operand into one of six classes: zero, denormal, normal, infinity, quiet NaN or signalling NaN. From those classes it decides whether the final answer is already known. That is the case for NaN propagation, invalid combinations, infinite results and results forced by a zero product.

When the answer is known, the block drives the finished IEEE-754 encoding and the invalid-operation flag. Otherwise it tells the datapath to go ahead. In either case it also supplies the effective product and addend signs. Two controls let the same screen serve the multiply-subtract and negated variants: one inverts the product sign and one inverts the addend sign. A rounding-direction input chooses the sign of an exactly cancelled zero.

The block is purely combinational.

Top module: `fma_special_screen`

## Requirements
- R1: Exactly one of `special_valid` and `go_datapath` is high for every input. `go_datapath` is high only when all of these hold: no operand is a NaN, no operand is an infinity, and neither x nor y is zero.
- R2: `prod_sign` equals x[31] XOR y[31], inverted when `neg_prod` is 1. `add_sign` equals z[31], inverted when `neg_addend` is 1.
- R3: When any operand is a signalling NaN (exponent all ones, bit 22 clear, fraction nonzero), the block picks the first one in the order z, x, y. It returns that operand with bit 22 set, the sign and the other bits unchanged, and raises `invalid_flag`.
- R4: When no operand is a signalling NaN but one is a quiet NaN (exponent all ones, bit 22 set), the block returns the first one in the order z, x, y, unchanged, with `invalid_flag` low.
- R5: Without NaNs, an infinity times a zero, in either order, returns `NAN_DEFAULT` (0x7FC00000) and raises `invalid_flag`.
- R6: Without NaNs, if the product is infinite and z is an infinity whose effective sign differs from `prod_sign`, the block returns `NAN_DEFAULT` with `invalid_flag`. Otherwise an infinite product returns an infinity carrying `prod_sign`.
- R7: Without NaNs, if the product is finite and z is an infinity, the result is an infinity carrying `add_sign`.
- R8: If the product is zero and z is a zero, the result depends on the signs. When `add_sign` equals `prod_sign`, the result is zero with that sign. When they differ, the result is +0, or -0 (0x80000000) when `round_down` is 1.
- R9: If the product is zero and z is finite and nonzero (denormals included), the result is z's exponent and fraction with `add_sign` as sign.
- R10: `invalid_flag` is high only in the cases of R3, R5 and R6. While `go_datapath` is high, `special_result` is 0 and `invalid_flag` is low.
- R11: A denormal operand (exponent 0, fraction nonzero) counts as finite and nonzero. A denormal times an infinity therefore yields an infinity, not the default NaN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_x | input | 32 | First multiplicand encoding |
| op_y | input | 32 | Second multiplicand encoding |
| op_z | input | 32 | Addend encoding |
| neg_prod | input | 1 | Invert the product sign |
| neg_addend | input | 1 | Invert the addend sign |
| round_down | input | 1 | Rounding toward minus infinity is in effect |
| special_valid | output | 1 | `special_result` is the final answer |
| special_result | output | 32 | Final encoding when `special_valid` is high, else 0 |
| invalid_flag | output | 1 | Invalid-operation exception |
| go_datapath | output | 1 | The arithmetic datapath must compute the result |
| prod_sign | output | 1 | Effective product sign |
| add_sign | output | 1 | Effective addend sign |

## Verification
The block holds no state, so a faulty class decode or a broken priority chain shows at the ports on the same evaluation as the input that triggers it. Typical symptoms are a wrong result encoding, a missing or spurious invalid flag, or both handshake outputs high together. Sweeping every triple of operand classes against both negate controls and both rounding settings puts each priority decision, each sign rule and each invalid case on the outputs within one vector of its inputs. Random encodings then probe the class boundaries, such as the quiet bit and the edges of the exponent range.

// File: rtl/fma_pkg.sv
package fma_pkg;
    typedef enum logic [2:0] {
        CLS_ZERO   = 3'd0,
        CLS_DENORM = 3'd1,
        CLS_NORM   = 3'd2,
        CLS_INF    = 3'd3,
        CLS_QNAN   = 3'd4,
        CLS_SNAN   = 3'd5
    } fp_class_e;

    localparam int unsigned NUM_OPS = 3;
    localparam int unsigned IDX_X   = 0;
    localparam int unsigned IDX_Y   = 1;
    localparam int unsigned IDX_Z   = 2;
endpackage

// File: rtl/fma_op_classifier.sv
module fma_op_classifier
    import fma_pkg::*;
#(
    parameter int unsigned EXP_W  = 8,
    parameter int unsigned FRAC_W = 23,
    localparam int unsigned W     = 1 + EXP_W + FRAC_W
) (
    input  logic [W-1:0] op_i,
    output fp_class_e    cls_o
);
    logic [EXP_W-1:0]  exp_w;
    logic [FRAC_W-1:0] frac_w;

    assign exp_w  = op_i[W-2 -: EXP_W];
    assign frac_w = op_i[FRAC_W-1:0];

    always_comb begin
        if (exp_w == '0) begin
            cls_o = (frac_w == '0) ? CLS_ZERO : CLS_DENORM;
        end else if (exp_w == '1) begin
            if (frac_w == '0)           cls_o = CLS_INF;
            else if (frac_w[FRAC_W-1])  cls_o = CLS_QNAN;
            else                        cls_o = CLS_SNAN;
        end else begin
            cls_o = CLS_NORM;
        end
    end
endmodule

// File: rtl/fma_sign_unit.sv
module fma_sign_unit #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] op_x_i,
    input  logic [W-1:0] op_y_i,
    input  logic [W-1:0] op_z_i,
    input  logic         neg_prod_i,
    input  logic         neg_add_i,
    output logic         prod_sign_o,
    output logic         add_sign_o
);
    assign prod_sign_o = op_x_i[W-1] ^ op_y_i[W-1] ^ neg_prod_i;
    assign add_sign_o  = op_z_i[W-1] ^ neg_add_i;
endmodule

// File: rtl/fma_special_resolver.sv
module fma_special_resolver
    import fma_pkg::*;
#(
    parameter int unsigned EXP_W       = 8,
    parameter int unsigned FRAC_W      = 23,
    parameter logic [31:0] NAN_DEFAULT = 32'h7FC0_0000,
    localparam int unsigned W          = 1 + EXP_W + FRAC_W
) (
    input  logic [W-1:0] op_x_i,
    input  logic [W-1:0] op_y_i,
    input  logic [W-1:0] op_z_i,
    input  fp_class_e    cls_x_i,
    input  fp_class_e    cls_y_i,
    input  fp_class_e    cls_z_i,
    input  logic         prod_sign_i,
    input  logic         add_sign_i,
    input  logic         round_down_i,
    output logic         special_o,
    output logic [W-1:0] result_o,
    output logic         invalid_o,
    output logic         proceed_o
);
    localparam logic [W-1:0] QUIET_MASK = W'(1) << (FRAC_W - 1);
    localparam logic [W-1:0] MAG_MASK   = {1'b0, {(W-1){1'b1}}};

    typedef struct packed {
        logic         special;
        logic [W-1:0] result;
        logic         invalid;
        logic         proceed;
    } res_t;

    res_t res_d;
    logic any_nan_d, any_inf_d, prod_inf_d, prod_zero_d;

    function automatic logic [W-1:0] make_inf(input logic s);
        return {s, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    endfunction

    always_comb begin
        any_nan_d   = (cls_x_i inside {CLS_QNAN, CLS_SNAN}) ||
                      (cls_y_i inside {CLS_QNAN, CLS_SNAN}) ||
                      (cls_z_i inside {CLS_QNAN, CLS_SNAN});
        any_inf_d   = (cls_x_i == CLS_INF) || (cls_y_i == CLS_INF) || (cls_z_i == CLS_INF);
        prod_inf_d  = (cls_x_i == CLS_INF) || (cls_y_i == CLS_INF);
        prod_zero_d = (cls_x_i == CLS_ZERO) || (cls_y_i == CLS_ZERO);

        res_d         = '0;
        res_d.proceed = !any_nan_d && !any_inf_d && !prod_zero_d;

        if (cls_z_i == CLS_SNAN) begin
            res_d.special = 1'b1; res_d.invalid = 1'b1;
            res_d.result  = op_z_i | QUIET_MASK;
        end else if (cls_x_i == CLS_SNAN) begin
            res_d.special = 1'b1; res_d.invalid = 1'b1;
            res_d.result  = op_x_i | QUIET_MASK;
        end else if (cls_y_i == CLS_SNAN) begin
            res_d.special = 1'b1; res_d.invalid = 1'b1;
            res_d.result  = op_y_i | QUIET_MASK;
        end else if (cls_z_i == CLS_QNAN) begin
            res_d.special = 1'b1; res_d.result = op_z_i;
        end else if (cls_x_i == CLS_QNAN) begin
            res_d.special = 1'b1; res_d.result = op_x_i;
        end else if (cls_y_i == CLS_QNAN) begin
            res_d.special = 1'b1; res_d.result = op_y_i;
        end else if (prod_inf_d && prod_zero_d) begin
            res_d.special = 1'b1; res_d.invalid = 1'b1;
            res_d.result  = NAN_DEFAULT[W-1:0];
        end else if (prod_inf_d) begin
            res_d.special = 1'b1;
            if (cls_z_i == CLS_INF && add_sign_i != prod_sign_i) begin
                res_d.invalid = 1'b1;
                res_d.result  = NAN_DEFAULT[W-1:0];
            end else begin
                res_d.result  = make_inf(prod_sign_i);
            end
        end else if (cls_z_i == CLS_INF) begin
            res_d.special = 1'b1;
            res_d.result  = make_inf(add_sign_i);
        end else if (prod_zero_d) begin
            res_d.special = 1'b1;
            if (cls_z_i == CLS_ZERO && add_sign_i != prod_sign_i)
                res_d.result = {round_down_i, {(W-1){1'b0}}};
            else
                res_d.result = {add_sign_i, op_z_i[W-2:0] & MAG_MASK[W-2:0]};
        end
    end

    assign special_o = res_d.special;
    assign result_o  = res_d.result;
    assign invalid_o = res_d.invalid;
    assign proceed_o = res_d.proceed;

    always_comb begin
        a_r1_one_of_two: assert ($onehot({res_d.special, res_d.proceed}))
            else $error("special and proceed not exclusive");
        a_r10_invalid_needs_special: assert (!res_d.invalid || res_d.special)
            else $error("invalid raised without special result");
        a_r10_go_quiet_result: assert (!res_d.proceed || (res_d.result == '0 && !res_d.invalid))
            else $error("proceed with nonzero result or flag");
        a_r3_snan_raises: assert (!(cls_x_i == CLS_SNAN || cls_y_i == CLS_SNAN || cls_z_i == CLS_SNAN)
                                  || (res_d.special && res_d.invalid))
            else $error("signalling NaN without invalid");
        a_r4_qnan_no_flag: assert (!(any_nan_d && !(cls_x_i == CLS_SNAN || cls_y_i == CLS_SNAN ||
                                    cls_z_i == CLS_SNAN)) || (res_d.special && !res_d.invalid))
            else $error("quiet NaN raised a flag");
    end
endmodule

// File: rtl/fma_special_screen.sv
module fma_special_screen
    import fma_pkg::*;
#(
    parameter int unsigned EXP_W       = 8,
    parameter int unsigned FRAC_W      = 23,
    parameter logic [31:0] NAN_DEFAULT = 32'h7FC0_0000,
    localparam int unsigned W          = 1 + EXP_W + FRAC_W
) (
    input  logic [W-1:0] op_x,
    input  logic [W-1:0] op_y,
    input  logic [W-1:0] op_z,
    input  logic         neg_prod,
    input  logic         neg_addend,
    input  logic         round_down,
    output logic         special_valid,
    output logic [W-1:0] special_result,
    output logic         invalid_flag,
    output logic         go_datapath,
    output logic         prod_sign,
    output logic         add_sign
);
    logic [W-1:0] ops_w [NUM_OPS];
    fp_class_e    cls_w [NUM_OPS];

    assign ops_w[IDX_X] = op_x;
    assign ops_w[IDX_Y] = op_y;
    assign ops_w[IDX_Z] = op_z;

    for (genvar i = 0; i < NUM_OPS; i++) begin : g_cls
        fma_op_classifier #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .op_i  (ops_w[i]),
            .cls_o (cls_w[i])
        );
    end

    fma_sign_unit #(.W(W)) u_sign (
        .op_x_i      (op_x),
        .op_y_i      (op_y),
        .op_z_i      (op_z),
        .neg_prod_i  (neg_prod),
        .neg_add_i   (neg_addend),
        .prod_sign_o (prod_sign),
        .add_sign_o  (add_sign)
    );

    fma_special_resolver #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .NAN_DEFAULT(NAN_DEFAULT)) u_res (
        .op_x_i       (op_x),
        .op_y_i       (op_y),
        .op_z_i       (op_z),
        .cls_x_i      (cls_w[IDX_X]),
        .cls_y_i      (cls_w[IDX_Y]),
        .cls_z_i      (cls_w[IDX_Z]),
        .prod_sign_i  (prod_sign),
        .add_sign_i   (add_sign),
        .round_down_i (round_down),
        .special_o    (special_valid),
        .result_o     (special_result),
        .invalid_o    (invalid_flag),
        .proceed_o    (go_datapath)
    );
endmodule

// File: tb/fma_special_screen_bench.sv
module fma_special_screen_bench;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [31:0] op_x, op_y, op_z;
    logic        neg_prod, neg_addend, round_down;
    logic        special_valid, invalid_flag, go_datapath, prod_sign, add_sign;
    logic [31:0] special_result;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    fma_special_screen u_fma_special_screen (
        .op_x(op_x), .op_y(op_y), .op_z(op_z),
        .neg_prod(neg_prod), .neg_addend(neg_addend), .round_down(round_down),
        .special_valid(special_valid), .special_result(special_result),
        .invalid_flag(invalid_flag), .go_datapath(go_datapath),
        .prod_sign(prod_sign), .add_sign(add_sign)
    );

    // class codes used by the bench: 0 zero,1 denormal,2 normal,3 inf,4 qnan,5 snan
    function automatic int cls_of(input logic [31:0] v);
        if (v[30:23] == 8'h00) return (v[22:0] == 0) ? 0 : 1;
        if (v[30:23] == 8'hFF) return (v[22:0] == 0) ? 3 : (v[22] ? 4 : 5);
        return 2;
    endfunction

    function automatic logic [31:0] mk(input int c, input logic s, input logic [31:0] r);
        case (c)
            0: return {s, 31'd0};
            1: return {s, 8'h00, r[22:0] | 23'd1};
            2: return {s, 8'(r[31:24] % 8'd254 + 8'd1), r[22:0]};
            3: return {s, 8'hFF, 23'd0};
            4: return {s, 8'hFF, 1'b1, r[21:0]};
            default: return {s, 8'hFF, 1'b0, r[21:0] | 22'd1};
        endcase
    endfunction

    // expected vector: {valid, result[31:0], invalid, go, psign, asign}
    task automatic model(input logic [31:0] x, y, z, input logic np, na, rd,
                         output logic [36:0] e, output string tag);
        int cx = cls_of(x), cy = cls_of(y), cz = cls_of(z);
        logic ps = x[31] ^ y[31] ^ np;
        logic as_ = z[31] ^ na;
        logic v = 1'b1, inv = 1'b0;
        logic [31:0] r = 32'd0;
        bit pinf = (cx == 3) || (cy == 3);
        bit pzero = (cx == 0) || (cy == 0);
        if      (cz == 5) begin r = z | 32'h0040_0000; inv = 1; tag = "R3"; end
        else if (cx == 5) begin r = x | 32'h0040_0000; inv = 1; tag = "R3"; end
        else if (cy == 5) begin r = y | 32'h0040_0000; inv = 1; tag = "R3"; end
        else if (cz == 4) begin r = z; tag = "R4"; end
        else if (cx == 4) begin r = x; tag = "R4"; end
        else if (cy == 4) begin r = y; tag = "R4"; end
        else if (pinf && pzero) begin r = 32'h7FC0_0000; inv = 1; tag = "R5"; end
        else if (pinf) begin
            if (cz == 3 && as_ != ps) begin r = 32'h7FC0_0000; inv = 1; end
            else r = {ps, 8'hFF, 23'd0};
            tag = (cx == 1 || cy == 1) ? "R11" : "R6";
        end
        else if (cz == 3) begin r = {as_, 8'hFF, 23'd0}; tag = "R7"; end
        else if (pzero) begin
            if (cz == 0) begin r = (as_ != ps) ? {rd, 31'd0} : {as_, 31'd0}; tag = "R8"; end
            else begin r = {as_, z[30:0]}; tag = "R9"; end
        end
        else begin v = 0; tag = "R1"; end
        e = {v, r, inv, ~v, ps, as_};
    endtask

    task automatic apply(input logic [31:0] x, y, z, input logic np, na, rd, input string extra);
        logic [36:0] exp_v, act;
        string tag;
        @(posedge clk);
        op_x = x; op_y = y; op_z = z; neg_prod = np; neg_addend = na; round_down = rd;
        @(negedge clk);
        model(x, y, z, np, na, rd, exp_v, tag);
        act = {special_valid, special_result, invalid_flag, go_datapath, prod_sign, add_sign};
        checks++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s %s (R2 R10 signs/flag) x=%h y=%h z=%h np=%0b na=%0b rd=%0b act=%h exp=%h",
                     tag, extra, x, y, z, np, na, rd, act, exp_v);
        end
    endtask

    initial begin
        op_x = 0; op_y = 0; op_z = 0; neg_prod = 0; neg_addend = 0; round_down = 0;
        // initial state: all zero inputs give +0 (R8)
        apply(32'h0, 32'h0, 32'h0, 0, 0, 0, "initial zero");
        // directed corners
        apply(32'h3F80_0000, 32'h4000_0000, 32'h4040_0000, 0, 0, 0, "R1 normal go");
        apply(32'h3F80_0000, 32'h4000_0000, 32'h0000_0000, 1, 1, 0, "R1 R2 zero addend go");
        apply(32'h7F80_0000, 32'h0000_0000, 32'h3F80_0000, 0, 0, 0, "R5 inf*0");
        apply(32'h8000_0000, 32'hFF80_0000, 32'h3F80_0000, 0, 0, 0, "R5 0*inf");
        apply(32'h7F80_0000, 32'h3F80_0000, 32'hFF80_0000, 0, 0, 0, "R6 inf-inf");
        apply(32'h7F80_0000, 32'h3F80_0000, 32'hFF80_0000, 0, 1, 0, "R6 inf+inf via negate");
        apply(32'h3F80_0000, 32'h3F80_0000, 32'h7F80_0000, 0, 1, 0, "R7 z inf");
        apply(32'h0000_0000, 32'h3F80_0000, 32'h8000_0000, 0, 0, 1, "R8 cancel rd");
        apply(32'h0000_0000, 32'h3F80_0000, 32'h8000_0000, 0, 0, 0, "R8 cancel rn");
        apply(32'h0000_0000, 32'h3F80_0000, 32'h0000_0001, 0, 1, 0, "R9 denorm z");
        apply(32'h0000_0001, 32'hFF80_0000, 32'h3F80_0000, 0, 0, 0, "R11 denorm*inf");
        apply(32'h7FA0_0001, 32'h7FC0_0002, 32'hFF80_0001, 0, 0, 0, "R3 z first");
        apply(32'h7FC0_0005, 32'hFF80_0003, 32'h7FC0_0007, 0, 0, 0, "R3 over qnan z");
        apply(32'h3F80_0000, 32'hFFC0_1234, 32'h7FC0_0009, 0, 0, 0, "R4 z first");
        apply(32'h7FC0_00AA, 32'h7FC0_00BB, 32'h3F80_0000, 0, 0, 0, "R4 x before y");
        // exhaustive class sweep
        for (int cz = 0; cz < 6; cz++)
            for (int cx = 0; cx < 6; cx++)
                for (int cy = 0; cy < 6; cy++)
                    for (int m = 0; m < 8; m++)
                        apply(mk(cx, 1'($urandom), $urandom), mk(cy, 1'($urandom), $urandom),
                              mk(cz, 1'($urandom), $urandom), m[0], m[1], m[2], "sweep");
        // constrained random plus raw random encodings
        for (int i = 0; i < 1500; i++)
            apply(mk(int'($urandom % 6), 1'($urandom), $urandom),
                  mk(int'($urandom % 6), 1'($urandom), $urandom),
                  mk(int'($urandom % 6), 1'($urandom), $urandom),
                  1'($urandom), 1'($urandom), 1'($urandom), "random class");
        for (int i = 0; i < 500; i++)
            apply($urandom, $urandom, $urandom, 1'($urandom), 1'($urandom), 1'($urandom), "random raw");
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        #(4 * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired act=running exp=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule